// File: doc/BRIEF.md
# Indexed Register Port Controller

This block gives a display controller a small window of byte-wide ports through which software reaches several register banks. Each ordinary bank uses two adjacent byte offsets. A write to the even offset latches a register index. A write to the odd offset stores a byte into the register that index selects. Reads of the same offsets return the latched index or the selected register.

The attribute bank has one port for both index and data. A phase flag decides whether a write to that port is an index or a data byte. A read of the status port returns the flag to its index phase. Software does this read before every index/data pair so that it always starts from a known phase. The index byte written to the attribute port also carries a video-output-enable bit, which the block drives out on its own pin. One further offset holds a miscellaneous output byte that is written directly and has no index.

Top module: `idx_regport`

## Requirements
- R1: After reset every bank register, every latched index, the attribute index, the video enable, the miscellaneous byte and the attribute phase are zero, and `rdata` is 0x00.
- R2: The five ordinary banks have index/data port pairs at 0x788/0x789, 0x79C/0x79D, 0x7A0/0x7A1, 0x7A8/0x7A9 and 0x7AC/0x7AD. A write to the even offset latches an 8-bit index, including indices as high as 0xD1. A write to the odd offset stores `wdata` into the register that index selects.
- R3: An index or data write to one bank leaves every other bank's index and registers unchanged.
- R4: Reads have one cycle of latency. `rdata` takes its new value at the clock edge that samples `rd_en`, and holds it while `rd_en` is low. A read of an even offset returns that bank's latched index. A read of an odd offset returns the register that index selects.
- R5: At 0x780, a write in index phase stores bits 4:0 as the attribute index and bit 5 as the video enable, then moves to data phase. A write in data phase stores the byte into the selected attribute register and returns to index phase.
- R6: A read of 0x7B4 returns the phase as it was before the read in bit 0 (1 means data phase), with the other bits zero. It also puts the phase back to index phase.
- R7: A read of 0x780 returns {2'b00, video enable, attribute index}. A read of 0x781 returns the selected attribute register. Neither read changes the phase.
- R8: A write to 0x784 stores the byte into the miscellaneous register, which drives `misc_out`. A read of 0x784 returns it.
- R9: Writes to any other offset have no effect, and reads of them return 0x00.
- R10: `video_en` follows bit 5 of the most recent attribute index-phase write and does not change on any other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset within the port window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| misc_out | output | 8 | Miscellaneous output register |
| video_en | output | 1 | Video output enable from the attribute index |

## Verification
The hardest case to reach is a desynchronised attribute phase: a status read that lands between an index write and its data write, or a data-port read placed inside a pair. The stimulus builds these cases on purpose. It writes an index, then reads the status port, and checks that the next write is taken as an index. It also reads 0x780 and 0x781 between the two halves of a pair. A long random mix of reads and writes over every mapped offset and several unmapped ones then keeps the phase wandering. The reference model follows it on every clock.

// File: rtl/idx_regport.sv
module idx_regport #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int IW = 8,
  parameter int AIW = 5,
  parameter int NB = 5,
  parameter logic [AW-1:0] BANK_BASE [NB] = '{12'h788, 12'h79C, 12'h7A0, 12'h7A8, 12'h7AC},
  parameter logic [AW-1:0] ATTR_A = 12'h780,
  parameter logic [AW-1:0] MISC_A = 12'h784,
  parameter logic [AW-1:0] STAT_A = 12'h7B4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] misc_out,
  output logic          video_en
);
  localparam int NREG  = 1 << IW;
  localparam int NAREG = 1 << AIW;
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [AW-1:0] ATTR_RD = AW'(ATTR_A + 1'b1);

  logic [DW-1:0]  regs  [NB][NREG];
  logic [IW-1:0]  idx   [NB];
  logic [DW-1:0]  aregs [NAREG];
  logic [AIW-1:0] ai;
  logic           ph;
  logic           hit;
  logic [BW-1:0]  hb;
  logic [DW-1:0]  rmux;

  always_comb begin
    hit = 1'b0;
    hb  = '0;
    for (int b = 0; b < NB; b++)
      if (addr[AW-1:1] == BANK_BASE[b][AW-1:1]) begin
        hit = 1'b1;
        hb  = BW'(b);
      end
  end

  always_comb begin
    rmux = '0;
    if (hit) rmux = addr[0] ? regs[hb][idx[hb]] : DW'(idx[hb]);
    else if (addr == ATTR_A)  rmux = DW'({video_en, ai});
    else if (addr == ATTR_RD) rmux = aregs[ai];
    else if (addr == MISC_A)  rmux = misc_out;
    else if (addr == STAT_A)  rmux = DW'(ph);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        idx[b] <= '0;
        for (int r = 0; r < NREG; r++) regs[b][r] <= '0;
      end
      for (int r = 0; r < NAREG; r++) aregs[r] <= '0;
      ai       <= '0;
      video_en <= 1'b0;
      ph       <= 1'b0;
      misc_out <= '0;
      rdata    <= '0;
    end else begin
      if (rd_en) rdata <= rmux;
      if (wr_en && hit) begin
        if (addr[0]) regs[hb][idx[hb]] <= wdata;
        else         idx[hb] <= wdata[IW-1:0];
      end
      if (wr_en && addr == ATTR_A) begin
        if (!ph) begin
          ai       <= wdata[AIW-1:0];
          video_en <= wdata[AIW];
        end else begin
          aregs[ai] <= wdata;
        end
        ph <= ~ph;
      end
      if (wr_en && addr == MISC_A) misc_out <= wdata;
      if (rd_en && addr == STAT_A) ph <= 1'b0;
    end
  end
endmodule

module idx_regport_chk #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] ATTR_A = 12'h780,
  parameter logic [AW-1:0] MISC_A = 12'h784,
  parameter logic [AW-1:0] STAT_A = 12'h7B4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] misc_out,
  input logic          video_en,
  input logic          ph
);
  p_phase_to_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ATTR_A && !ph) |=> ph);
  p_phase_to_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ATTR_A && ph) |=> !ph);
  p_status_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == STAT_A) |=> !ph);
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  p_misc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == MISC_A) |=> $stable(misc_out));
  p_ve_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ATTR_A && !ph) |=> $stable(video_en));
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == ATTR_A) && !(rd_en && addr == STAT_A)) |=> $stable(ph));
endmodule

bind idx_regport idx_regport_chk #(.AW(AW), .DW(DW), .ATTR_A(ATTR_A), .MISC_A(MISC_A), .STAT_A(STAT_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .misc_out(misc_out), .video_en(video_en), .ph(ph)
);

// File: tb/tb_idx_regport.sv
module tb_idx_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, misc_out;
  logic        video_en;

  idx_regport dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .misc_out(misc_out), .video_en(video_en));

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_mem [int];
  int m_idx [5];
  int m_attr [32];
  int m_aidx, m_ve, m_ph, m_misc, m_rdata;

  function automatic int bank_num(input int a);
    case (a >> 1)
      12'h788 >> 1: return 0;
      12'h79C >> 1: return 1;
      12'h7A0 >> 1: return 2;
      12'h7A8 >> 1: return 3;
      12'h7AC >> 1: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int mem_get(input int b, input int i);
    int k;
    k = b * 256 + i;
    return m_mem.exists(k) ? m_mem[k] : 0;
  endfunction

  function automatic int model_read(input int a);
    int b;
    b = bank_num(a);
    if (b >= 0) return (a % 2) ? mem_get(b, m_idx[b]) : m_idx[b];
    if (a == 12'h780) return m_ve * 32 + m_aidx;
    if (a == 12'h781) return m_attr[m_aidx];
    if (a == 12'h784) return m_misc;
    if (a == 12'h7B4) return m_ph;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mem.delete();
      foreach (m_idx[b]) m_idx[b] = 0;
      foreach (m_attr[r]) m_attr[r] = 0;
      m_aidx = 0; m_ve = 0; m_ph = 0; m_misc = 0; m_rdata = 0;
    end else begin
      int a, d, b;
      a = int'(addr);
      d = int'(wdata);
      b = bank_num(a);
      if (rd_en) m_rdata = model_read(a);
      if (wr_en) begin
        if (b >= 0) begin
          if (a % 2) m_mem[b * 256 + m_idx[b]] = d;
          else m_idx[b] = d;
        end else if (a == 12'h780) begin
          if (m_ph == 0) begin
            m_aidx = d % 32;
            m_ve = (d / 32) % 2;
            m_ph = 1;
          end else begin
            m_attr[m_aidx] = d;
            m_ph = 0;
          end
        end else if (a == 12'h784) m_misc = d;
      end
      if (rd_en && a == 12'h7B4) m_ph = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks += 3;
      if (int'(rdata) != m_rdata) begin
        errors++;
        $display("FAIL %s rdata actual=%02h expected=%02h", cur_req, rdata, m_rdata);
      end
      if (int'(misc_out) != m_misc) begin
        errors++;
        $display("FAIL %s misc_out actual=%02h expected=%02h", cur_req, misc_out, m_misc);
      end
      if (int'(video_en) != m_ve) begin
        errors++;
        $display("FAIL %s video_en actual=%0d expected=%0d", cur_req, video_en, m_ve);
      end
    end
  end

  task automatic op(input bit w, input bit r, input int a, input int d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 12'(a); wdata = 8'(d);
  endtask

  task automatic wr(input int a, input int d); op(1, 0, a, d); endtask
  task automatic rd(input int a); op(0, 1, a, 0); endtask
  task automatic idle(); op(0, 0, 0, 0); endtask

  task automatic expect_rd(input int a, input int exp);
    rd(a);
    idle();
    checks++;
    if (int'(rdata) != exp) begin
      errors++;
      $display("FAIL %s read %03h actual=%02h expected=%02h", cur_req, a, rdata, exp);
    end
  endtask

  initial begin
    int bases [5] = '{12'h788, 12'h79C, 12'h7A0, 12'h7A8, 12'h7AC};
    int pool [16] = '{12'h788, 12'h789, 12'h79C, 12'h79D, 12'h7A0, 12'h7A1, 12'h7A8, 12'h7A9,
                      12'h7AC, 12'h7AD, 12'h780, 12'h781, 12'h784, 12'h7B4, 12'h7B0, 12'h000};
    cur_req = "R1";
    repeat (3) idle();
    rst_n = 1'b1;
    expect_rd(12'h7AD, 0);
    expect_rd(12'h781, 0);
    expect_rd(12'h7B4, 0);

    cur_req = "R2";
    foreach (bases[b]) begin
      wr(bases[b], 16 + b);
      wr(bases[b] + 1, 8'hA0 + b);
    end
    wr(12'h7AC, 8'hD1);
    wr(12'h7AD, 8'h5C);
    foreach (bases[b]) begin
      wr(bases[b], 16 + b);
      expect_rd(bases[b] + 1, 8'hA0 + b);
    end
    wr(12'h7AC, 8'hD1);
    expect_rd(12'h7AD, 8'h5C);

    cur_req = "R3";
    wr(12'h788, 5); wr(12'h789, 8'hAA);
    wr(12'h79C, 5); wr(12'h79D, 8'h55);
    expect_rd(12'h789, 8'hAA);
    expect_rd(12'h788, 5);
    expect_rd(12'h79C, 5);

    cur_req = "R4";
    rd(12'h79D);
    repeat (4) idle();
    expect_rd(12'h79D, 8'h55);

    cur_req = "R5";
    rd(12'h7B4);
    wr(12'h780, 8'h30);
    wr(12'h780, 8'h01);
    wr(12'h780, 8'h12);
    wr(12'h780, 8'h0F);
    expect_rd(12'h7B4, 0);

    cur_req = "R6";
    wr(12'h780, 8'h10);
    expect_rd(12'h7B4, 1);
    wr(12'h780, 8'h33);
    expect_rd(12'h7B4, 1);
    expect_rd(12'h7B4, 0);

    cur_req = "R7";
    wr(12'h780, 8'h30);
    expect_rd(12'h780, 8'h30);
    expect_rd(12'h781, 8'h01);
    wr(12'h780, 8'h77);
    wr(12'h780, 8'h30);
    expect_rd(12'h781, 8'h77);

    cur_req = "R8";
    wr(12'h784, 8'hC7);
    expect_rd(12'h784, 8'hC7);

    cur_req = "R9";
    wr(12'h7B0, 8'hFF);
    wr(12'h785, 8'hFF);
    expect_rd(12'h7B0, 0);
    expect_rd(12'hFFF, 0);
    expect_rd(12'h784, 8'hC7);

    cur_req = "R10";
    rd(12'h7B4);
    wr(12'h780, 8'h05);
    wr(12'h780, 8'h20);
    wr(12'h781, 8'h20);
    idle();
    checks++;
    if (video_en !== 1'b0) begin
      errors++;
      $display("FAIL R10 video_en actual=%0d expected=0", video_en);
    end

    cur_req = "R2 R4 R5 R6 random";
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = pool[$urandom_range(15)];
      op($urandom_range(1), $urandom_range(1), a, $urandom_range(255));
    end
    idle();
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule